// File: doc/BRIEF.md
# Float-to-Integer Multi-Semantics Converter

This block turns a 64-bit binary floating-point operand into a 64-bit integer register value. The target integer type can be signed or unsigned, 32 or 64 bits wide. A conversion-mode field chooses how NaN and out-of-range values are treated. The legacy modes clamp to the type limits and send a NaN to the type minimum. The saturating modes clamp the same way but send a NaN to zero. The wrap modes keep the low bits of the rounded integer modulo 2^64, the way a scripting language does. Along with the result come six status bits: invalid conversion, signalling-NaN invalid, inexact, fraction rounded up, overflow and illegal mode.

Each conversion travels on a valid/ready handshake. The block is a combinational rounding front end and a semantics selector, followed by one output register. Each accepted operand gives exactly one result beat, one clock later. A result held under back-pressure stays stable until the consumer takes it.

Top module: `fcvt_int_conv`

## Requirements
- R1: `in_ready` is high whenever the output register is empty or `out_ready` is high. An operand accepted on a clock edge appears on the outputs with `out_valid` high right after that edge. While `out_valid` is high and `out_ready` is low, the result and flags hold.
- R2: Type encoding: 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 64-bit and 3 is unsigned 64-bit. Type bit 0 selects unsigned and type bit 1 selects 64-bit. For 32-bit types, the low 32 bits of the result are sign-extended (signed) or zero-extended (unsigned) to 64 bits.
- R3: Rounding is toward zero when mode bit 0 is 1 or the rounding input is 01. Otherwise rounding input 00 rounds to nearest with ties to even, 10 rounds toward +infinity and 11 rounds toward -infinity.
- R4: Modes 0 and 1: a NaN gives the type minimum. A rounded value above the maximum gives the maximum, and one below the minimum gives the minimum. Any other value gives the rounded integer.
- R5: Modes 2 and 3 clamp out-of-range values the same way as modes 0 and 1, but a NaN gives zero.
- R6: Modes 4 and 5: an infinity or a NaN gives zero. Any other value gives the rounded integer modulo 2^64, with the low 32 bits extended per R2 for 32-bit types.
- R7: Modes 6 and 7 raise the illegal flag and give a zero result with all other flags zero.
- R8: Invalid conversion and overflow are both set when the operand is a NaN or the rounded value lies outside the target type's range. In that case inexact and fraction-rounded are both 0.
- R9: Otherwise inexact is set when the result differs from the operand value. Fraction-rounded is set when the result's magnitude exceeds the operand's magnitude.
- R10: A signalling NaN (exponent all ones, fraction nonzero, fraction MSB 0) sets the signalling-NaN flag as well as invalid conversion. A quiet NaN does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_op | input | 64 | Floating-point operand (sign, 11-bit exponent, 52-bit fraction) |
| in_type | input | 2 | Target integer type |
| in_mode | input | 3 | Conversion semantics |
| in_rm | input | 2 | Rounding mode |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Converted integer |
| out_inv | output | 1 | Invalid conversion |
| out_snan | output | 1 | Signalling-NaN invalid |
| out_inexact | output | 1 | Result differs from operand |
| out_fr | output | 1 | Fraction was rounded up in magnitude |
| out_ovf | output | 1 | Overflow |
| out_illegal | output | 1 | Illegal mode encoding |

## Verification
Every operand in a fixed set is tried under every combination of type, mode and rounding mode. The set covers signed zeros, ties at .5 with odd and even integer parts, small fractions of both signs, the exact limits of each integer type and one step past them, values near and beyond 2^64 with low bits set, infinities, quiet and signalling NaNs, and a denormal. The ties separate the four rounding directions. The limit values separate in-range results from clamped results for each type. The values beyond 2^64 show whether the wrap modes keep the right low bits while the clamping modes saturate. A separate back-pressure sequence stalls the consumer to check that a second operand waits and the held result does not change.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam int unsigned OP_W   = 1 + EXP_W + FRAC_W;
  localparam int unsigned MANT_W = FRAC_W + 1;
  localparam int unsigned INT_W  = 64;
  localparam int unsigned HALF_W = INT_W / 2;
  localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    CM_CLAMP_MIN = 2'b00,
    CM_CLAMP_ZERO = 2'b01,
    CM_WRAP = 2'b10,
    CM_BAD = 2'b11
  } cmode_e;

  typedef struct packed {
    logic             sign;
    logic             is_nan;
    logic             is_snan;
    logic             is_inf;
    logic             huge;
    logic [INT_W-1:0] mag;
    logic             inexact;
    logic             rnd_up;
  } rnd_t;

  typedef struct packed {
    logic inv;
    logic snan;
    logic inexact;
    logic fr;
    logic ovf;
    logic illegal;
  } flags_t;
endpackage

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [1:0]      rm_i,
  input  logic            trunc_i,
  output rnd_t            rnd_o
);
  localparam logic [EXP_W-1:0] E_HALF = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] E_INT  = EXP_W'(BIAS + FRAC_W);
  localparam logic [EXP_W-1:0] E_HUGE = EXP_W'(BIAS + INT_W);

  logic                      sign;
  logic [EXP_W-1:0]          expo;
  logic [FRAC_W-1:0]         frac;
  logic [MANT_W-1:0]         mant;
  logic                      special;
  logic [EXP_W-1:0]          rsh;
  logic [EXP_W-1:0]          lsh;
  logic [MANT_W+INT_W-1:0]   aligned;
  logic [INT_W-1:0]          ipart;
  logic                      guard;
  logic                      sticky;
  logic                      huge;
  logic                      inc;
  rmode_e                    rm_eff;

  assign sign    = op_i[OP_W-1];
  assign expo    = op_i[OP_W-2 -: EXP_W];
  assign frac    = op_i[FRAC_W-1:0];
  assign mant    = {|expo, frac};
  assign special = &expo;

  // align the significand on the binary point; split integer and fraction
  always_comb begin
    rsh     = '0;
    lsh     = '0;
    aligned = '0;
    ipart   = '0;
    guard   = 1'b0;
    sticky  = 1'b0;
    huge    = 1'b0;
    if (special) begin
      huge = 1'b1;
    end else if (expo < E_HALF) begin
      sticky = |{expo, frac};
    end else if (expo < E_INT) begin
      rsh     = E_INT - expo;
      aligned = {mant, {INT_W{1'b0}}} >> rsh;
      ipart   = {{(INT_W-MANT_W){1'b0}}, aligned[MANT_W+INT_W-1:INT_W]};
      guard   = aligned[INT_W-1];
      sticky  = |aligned[INT_W-2:0];
    end else begin
      lsh   = expo - E_INT;
      ipart = {{(INT_W-MANT_W){1'b0}}, mant} << lsh;
      huge  = (expo >= E_HUGE);
    end
  end

  // rounding direction: mode bit 0 forces truncation
  always_comb begin
    rm_eff = trunc_i ? RM_ZERO : rmode_e'(rm_i);
    unique case (rm_eff)
      RM_NEAR: inc = guard & (sticky | ipart[0]);
      RM_UP:   inc = ~sign & (guard | sticky);
      RM_DOWN: inc = sign & (guard | sticky);
      default: inc = 1'b0;
    endcase
  end

  always_comb begin
    rnd_o.sign    = sign;
    rnd_o.is_nan  = special & (|frac);
    rnd_o.is_snan = special & (|frac) & ~frac[FRAC_W-1];
    rnd_o.is_inf  = special & ~(|frac);
    rnd_o.huge    = huge;
    rnd_o.mag     = ipart + {{(INT_W-1){1'b0}}, inc};
    rnd_o.inexact = guard | sticky;
    rnd_o.rnd_up  = inc;
  end
endmodule

// File: rtl/fcvt_select.sv
module fcvt_select
  import fcvt_pkg::*;
(
  input  rnd_t             rnd_i,
  input  logic [1:0]       type_i,
  input  logic [2:0]       mode_i,
  output logic [INT_W-1:0] result_o,
  output flags_t           flags_o
);
  localparam logic [INT_W-1:0] ALL1 = {INT_W{1'b1}};
  localparam logic [INT_W-1:0] ONE  = {{(INT_W-1){1'b0}}, 1'b1};

  logic             is_uns;
  logic             is_wide;
  logic [INT_W-1:0] pos_lim;
  logic [INT_W-1:0] neg_lim;
  logic [INT_W-1:0] min_val;
  logic             in_range;
  logic             bad;
  logic [INT_W-1:0] sval;
  logic [INT_W-1:0] clamped;
  logic [INT_W-1:0] raw;
  logic [INT_W-1:0] ext;
  cmode_e           cm;

  assign is_uns  = type_i[0];
  assign is_wide = type_i[1];
  assign cm      = cmode_e'(mode_i[2:1]);

  // largest positive magnitude and largest negative magnitude per type
  always_comb begin
    if (is_uns) begin
      pos_lim = ALL1 >> (is_wide ? 0 : HALF_W);
      neg_lim = '0;
    end else begin
      pos_lim = ALL1 >> (is_wide ? 1 : HALF_W + 1);
      neg_lim = ONE << (is_wide ? INT_W - 1 : HALF_W - 1);
    end
    min_val  = '0 - neg_lim;
    in_range = ~rnd_i.huge & (rnd_i.sign ? (rnd_i.mag <= neg_lim)
                                          : (rnd_i.mag <= pos_lim));
    bad      = rnd_i.is_nan | ~in_range;
  end

  assign sval    = rnd_i.sign ? ('0 - rnd_i.mag) : rnd_i.mag;
  assign clamped = ~in_range ? (rnd_i.sign ? min_val : pos_lim) : sval;

  always_comb begin
    unique case (cm)
      CM_CLAMP_MIN:  raw = rnd_i.is_nan ? min_val : clamped;
      CM_CLAMP_ZERO: raw = rnd_i.is_nan ? '0 : clamped;
      CM_WRAP:       raw = (rnd_i.is_nan | rnd_i.is_inf) ? '0 : sval;
      default:       raw = '0;
    endcase
  end

  always_comb begin
    if (is_wide)     ext = raw;
    else if (is_uns) ext = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    else             ext = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
  end

  always_comb begin
    flags_o.illegal = (cm == CM_BAD);
    flags_o.inv     = ~flags_o.illegal & bad;
    flags_o.ovf     = ~flags_o.illegal & bad;
    flags_o.snan    = ~flags_o.illegal & rnd_i.is_snan;
    flags_o.inexact = ~flags_o.illegal & ~bad & rnd_i.inexact;
    flags_o.fr      = ~flags_o.illegal & ~bad & rnd_i.rnd_up;
    result_o        = flags_o.illegal ? '0 : ext;
  end
endmodule

// File: rtl/fcvt_int_conv.sv
module fcvt_int_conv
  import fcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [1:0]       in_type,
  input  logic [2:0]       in_mode,
  input  logic [1:0]       in_rm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [INT_W-1:0] out_result,
  output logic             out_inv,
  output logic             out_snan,
  output logic             out_inexact,
  output logic             out_fr,
  output logic             out_ovf,
  output logic             out_illegal
);
  rnd_t             rnd_w;
  logic [INT_W-1:0] res_w;
  flags_t           flg_w;

  logic             valid_q;
  logic             valid_d;
  logic             accept;
  logic [INT_W-1:0] res_q;
  flags_t           flg_q;

  fcvt_round u_round (
    .op_i    (in_op),
    .rm_i    (in_rm),
    .trunc_i (in_mode[0]),
    .rnd_o   (rnd_w)
  );

  fcvt_select u_sel (
    .rnd_i    (rnd_w),
    .type_i   (in_type),
    .mode_i   (in_mode),
    .result_o (res_w),
    .flags_o  (flg_w)
  );

  // handshake next state
  always_comb begin
    in_ready = ~valid_q | out_ready;
    accept   = in_valid & in_ready;
    valid_d  = accept | (valid_q & ~out_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // payload register, loaded only on acceptance
  always_ff @(posedge clk) begin
    if (accept) begin
      res_q <= res_w;
      flg_q <= flg_w;
    end
  end

  assign out_valid   = valid_q;
  assign out_result  = res_q;
  assign out_inv     = flg_q.inv;
  assign out_snan    = flg_q.snan;
  assign out_inexact = flg_q.inexact;
  assign out_fr      = flg_q.fr;
  assign out_ovf     = flg_q.ovf;
  assign out_illegal = flg_q.illegal;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_inv)
                                && $stable(out_inexact));

  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0 && !out_inv && !out_snan
                                 && !out_inexact && !out_fr && !out_ovf);

  p_inv_clears_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_inv |-> !out_inexact && !out_fr && out_ovf);

  p_fr_needs_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fr |-> out_inexact);

  p_snan_is_inv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_snan |-> out_inv);
endmodule

// File: tb/fcvt_int_conv_bench.sv
`timescale 1ns/1ps
module fcvt_int_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_op;
  logic [1:0]  in_type;
  logic [2:0]  in_mode;
  logic [1:0]  in_rm;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_result;
  logic        out_inv, out_snan, out_inexact, out_fr, out_ovf, out_illegal;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  localparam int NV = 28;
  logic [63:0] vals [NV];

  always #2 clk = ~clk;

  fcvt_int_conv u_fcvt_int_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_type(in_type), .in_mode(in_mode), .in_rm(in_rm),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_inv(out_inv), .out_snan(out_snan), .out_inexact(out_inexact),
    .out_fr(out_fr), .out_ovf(out_ovf), .out_illegal(out_illegal)
  );

  localparam real P63 = 9223372036854775808.0;
  localparam real P64 = 18446744073709551616.0;

  // R3 rounding reference
  function automatic real round_ref(real x, logic trunc, logic [1:0] rm);
    real fl, d;
    if (x == x + 1.0) return x;
    fl = $floor(x);
    if (trunc || rm == 2'b01) return (x < 0.0) ? $ceil(x) : fl;
    if (rm == 2'b10) return $ceil(x);
    if (rm == 2'b11) return fl;
    d = x - fl;
    if (d > 0.5) return fl + 1.0;
    if (d < 0.5) return fl;
    return ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
  endfunction

  function automatic bit in_range_ref(real r, logic [1:0] t);
    case (t)
      2'd0:    return r >= -2147483648.0 && r <= 2147483647.0;
      2'd1:    return r >= 0.0 && r <= 4294967295.0;
      2'd2:    return r >= -P63 && r < P63;
      default: return r >= 0.0 && r < P64;
    endcase
  endfunction

  function automatic logic [63:0] r2bits(real r);
    if (r >= P63) return 64'(longint'(r - P63)) | 64'h8000_0000_0000_0000;
    return 64'(longint'(r));
  endfunction

  // R2 extension reference
  function automatic logic [63:0] ext_ref(logic [63:0] v, logic [1:0] t);
    if (t[1]) return v;
    if (t[0]) return {32'h0, v[31:0]};
    return {{32{v[31]}}, v[31:0]};
  endfunction

  function automatic logic [63:0] tmin(logic [1:0] t);
    case (t)
      2'd0:    return 64'hFFFF_FFFF_8000_0000;
      2'd2:    return 64'h8000_0000_0000_0000;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [63:0] tmax(logic [1:0] t);
    case (t)
      2'd0:    return 64'h0000_0000_7FFF_FFFF;
      2'd1:    return 64'h0000_0000_FFFF_FFFF;
      2'd2:    return 64'h7FFF_FFFF_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  task automatic model(input logic [63:0] op, input logic [1:0] t, input logic [2:0] md,
                       input logic [1:0] rm, output logic [63:0] res, output logic [5:0] fl);
    bit  is_nan, is_inf, is_snan, ok;
    real x, r, a, m;
    logic [63:0] b;
    is_nan  = (op[62:52] == 11'h7FF) && (op[51:0] != 0);
    is_inf  = (op[62:52] == 11'h7FF) && (op[51:0] == 0);
    is_snan = is_nan && !op[51];
    if (md[2:1] == 2'b11) begin
      res = 64'h0; fl = 6'b000001;
      return;
    end
    x  = $bitstoreal(op);
    r  = is_nan ? 0.0 : round_ref(x, md[0], rm);
    ok = !is_nan && in_range_ref(r, t);
    if (md[2:1] == 2'b10) begin
      if (is_nan || is_inf) b = 64'h0;
      else begin
        a = (r < 0.0) ? -r : r;
        m = a - P64 * $floor(a / P64);
        b = r2bits(m);
        if (r < 0.0) b = 64'h0 - b;
      end
    end else if (is_nan) b = (md[2:1] == 2'b00) ? tmin(t) : 64'h0;
    else if (!ok)        b = (r < 0.0) ? tmin(t) : tmax(t);
    else                 b = r2bits(r);
    res = ext_ref(b, t);
    fl  = {!ok, is_snan, ok && (r != x), ok && ((r < 0.0 ? -r : r) > (x < 0.0 ? -x : x)),
           !ok, 1'b0};
  endtask

  task automatic check(input bit cond, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [63:0] op, input logic [1:0] t, input logic [2:0] md,
                         input logic [1:0] rm);
    logic [63:0] er;
    logic [5:0]  ef, af;
    string       tag;
    @(negedge clk);
    in_op = op; in_type = t; in_mode = md; in_rm = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(op, t, md, rm, er, ef);
    af = {out_inv, out_snan, out_inexact, out_fr, out_ovf, out_illegal};
    case (md[2:1])
      2'b00:   tag = "R4 (R2 R3)";
      2'b01:   tag = "R5 (R2 R3)";
      2'b10:   tag = "R6 (R2 R3)";
      default: tag = "R7";
    endcase
    check(out_valid && out_result == er, $sformatf("%s result op=%h t=%0d m=%0d rm=%0d",
          tag, op, t, md, rm), out_result, er);
    check(af == ef, $sformatf("R8 R9 R10 R7 flags op=%h t=%0d m=%0d rm=%0d", op, t, md, rm),
          64'(af), 64'(ef));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    vals[0]  = 64'h0000_0000_0000_0000;
    vals[1]  = 64'h8000_0000_0000_0000;
    vals[2]  = $realtobits(0.5);
    vals[3]  = $realtobits(1.5);
    vals[4]  = $realtobits(2.5);
    vals[5]  = $realtobits(-2.5);
    vals[6]  = $realtobits(0.3);
    vals[7]  = $realtobits(-0.3);
    vals[8]  = $realtobits(-0.7);
    vals[9]  = $realtobits(3.7);
    vals[10] = $realtobits(2147483646.5);
    vals[11] = $realtobits(2147483647.0);
    vals[12] = $realtobits(2147483648.0);
    vals[13] = $realtobits(-2147483648.0);
    vals[14] = $realtobits(-2147483648.5);
    vals[15] = $realtobits(4294967295.0);
    vals[16] = $realtobits(4294967296.0);
    vals[17] = $realtobits(P63);
    vals[18] = $realtobits(-P63);
    vals[19] = $realtobits(P64);
    vals[20] = $realtobits(1180591620717412433920.0 + 1048576.0);
    vals[21] = $realtobits(-3.0e20);
    vals[22] = $realtobits(1.0e300);
    vals[23] = 64'h7FF0_0000_0000_0000;
    vals[24] = 64'hFFF0_0000_0000_0000;
    vals[25] = 64'h7FF8_0000_0000_0001;
    vals[26] = 64'hFFF4_0000_0000_0000;
    vals[27] = 64'h0000_0000_0000_0001;

    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_op = '0; in_type = '0; in_mode = '0; in_rm = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1 reset state", {62'h0, out_valid, in_ready}, 64'h1);
    rst_n = 1'b1;

    // R1 back-pressure: second operand waits, held result stays
    @(negedge clk);
    out_ready = 1'b0;
    in_op = $realtobits(2.5); in_type = 2'd2; in_mode = 3'd0; in_rm = 2'd0; in_valid = 1'b1;
    @(negedge clk);
    in_op = $realtobits(7.0);
    check(out_valid && !in_ready && out_result == 64'd2, "R1 stall captured",
          out_result, 64'd2);
    repeat (2) @(negedge clk);
    check(out_valid && out_result == 64'd2 && out_inexact, "R1 stall holds",
          out_result, 64'd2);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == 64'd7 && !out_inexact, "R1 waiting operand taken",
          out_result, 64'd7);
    @(negedge clk);
    check(!out_valid, "R1 drained", {63'h0, out_valid}, 64'h0);

    for (int v = 0; v < NV; v++)
      for (int t = 0; t < 4; t++)
        for (int md = 0; md < 8; md++)
          for (int rm = 0; rm < 4; rm++)
            convert(vals[v], 2'(t), 3'(md), 2'(rm));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule